// File: doc/BRIEF.md
# Quadrature Up/Down Counter Channel

This block is one counting channel for a rotary or linear encoder. Two count inputs, A and B, pass through a sampling stage. They are decoded either as a step/direction pair or as a quadrature pair at one, two or four counts per cycle. The result is a stream of up and down steps that drives a 24-bit counter. The counter has a floor of zero. Its ceiling is either the full 24-bit maximum or the preset value, depending on the selected count mode. The count mode decides what happens at the ends of the range: wrap, hold, freeze, or modulo-N wrap.

An index input can load the preset into the counter. The active level of the index input is selectable. A gated (synchronous) index option is available only when the decoder is in a quadrature mode. When that option is on, a load happens only if the A and B samples are both low at the index edge.

Configuration is written through a small word-wide port that selects one of four internal registers. The outputs are:
- the count
- the last counting direction
- one-cycle carry and borrow pulses
- a compare flag that is high while the count equals the preset

Top module: `quad_count_chan`

## Requirements
- R1: After reset the count is 0, the direction output is 1 (up), carry and borrow are 0, and compare is 1 because the preset is also 0. Reset also selects step/direction decoding and normal count mode. It leaves A/B gated off, index loading enabled, the gated index option off, and index polarity active-low.
- R2: A write with `cfg_we` high updates the register selected by `cfg_sel` at the next clock edge:
  - 0 = mode register: `cfg_data[4:3]` is the decoder (0 step/direction, 1 x1, 2 x2, 3 x4) and `cfg_data[2:1]` is the count mode (0 normal, 1 range-limit, 2 non-recycle, 3 modulo-N).
  - 1 = input register: bit 0 = 1 lets A/B count; bit 1 = 0 lets the index load the counter.
  - 2 = index register: bit 0 = gated index option; bit 1 = 1 for active-high index.
  - 3 = preset: all 24 bits.
- R3: While input register bit 0 is 0, A/B activity never changes the count or the direction.
- R4: In step/direction decoding, a rising edge of A counts up when B is 1 and down when B is 0. A falling edge of A and any change of B do not count.
- R5: In x1 decoding, the transition AB=00 to 10 counts up and the transition 10 to 00 counts down. No other transition counts, so one full forward cycle adds 1.
- R6: In x2 decoding, every valid transition in which A changes counts, so one full forward cycle adds 2.
- R7: In x4 decoding, the forward sequence is AB 00, 10, 11, 01 and every valid transition counts. A transition in which A and B change together is ignored. The direction output shows the direction of the last counted step.
- R8: In normal mode, counting up from 0xFFFFFF gives 0 with a one-cycle carry pulse. Counting down from 0 gives 0xFFFFFF with a one-cycle borrow pulse.
- R9: In range-limit mode the ceiling is the preset. Counting up at or above the ceiling holds the count and pulses carry. Counting down at 0 holds the count and pulses borrow.
- R10: In non-recycle mode, a wrap at either end of the 24-bit range pulses carry or borrow and then freezes the count. The count stays frozen until an index load.
- R11: In modulo-N mode the ceiling is the preset. Counting up at or above the ceiling gives 0 with a carry pulse. Counting down at 0 gives the preset value with a borrow pulse.
- R12: With input register bit 1 at 0, a change of the index input into its active level loads the preset into the count. A load takes precedence over a count in the same cycle. With bit 1 at 1, the index input has no effect.
- R13: With the gated index option on, an index edge loads only when the A and B samples are both 0. Setting the option is refused while the decoder is step/direction, and selecting step/direction clears it.
- R14: The compare output is 1 exactly while the count equals the preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 input, 2 index, 3 preset |
| cfg_data | input | CNT_W | Configuration write data |
| in_a | input | 1 | Count input A |
| in_b | input | 1 | Count input B |
| in_idx | input | 1 | Index / load input |
| count_o | output | CNT_W | Counter value |
| dir_up_o | output | 1 | 1 when the last counted step was up |
| carry_o | output | 1 | One-cycle pulse on an upper-end event |
| borrow_o | output | 1 | One-cycle pulse on a lower-end event |
| compare_o | output | 1 | Count equals preset |

## Verification
Timing of each result:
- A change on A, B or the index input is captured by the sampling register at the first clock edge. The count, the direction and the carry or borrow pulse are updated at the second edge.
- A configuration write takes effect at the edge that captures it.
- Compare follows the count and the preset with no extra stage.

The bench therefore changes inputs on a falling clock edge and waits two more falling edges before sampling. At that point the second rising edge has passed and any one-cycle pulse is still high. Pulses are also sampled one cycle later to confirm they have dropped.

// File: rtl/qc_pkg.sv
package qc_pkg;

  typedef enum logic [1:0] {
    DEC_STEP_DIR = 2'd0,
    DEC_X1       = 2'd1,
    DEC_X2       = 2'd2,
    DEC_X4       = 2'd3
  } dec_e;

  typedef enum logic [1:0] {
    CM_NORMAL  = 2'd0,
    CM_RANGE   = 2'd1,
    CM_NOREC   = 2'd2,
    CM_MODULO  = 2'd3
  } cmode_e;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_INPUT  = 2'd1,
    SEL_INDEX  = 2'd2,
    SEL_PRESET = 2'd3
  } csel_e;

  typedef struct packed {
    dec_e   dec;
    cmode_e cmode;
    logic   ab_en;
    logic   idx_load_n;
    logic   idx_sync;
    logic   idx_pos;
  } cfg_t;

endpackage

// File: rtl/qc_cfg_regs.sv
module qc_cfg_regs
  import qc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [CNT_W-1:0] data,
  output cfg_t             cfg,
  output logic [CNT_W-1:0] preset
);

  localparam logic [1:0] DEC_SD_CODE = 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.dec        <= DEC_STEP_DIR;
      cfg.cmode      <= CM_NORMAL;
      cfg.ab_en      <= 1'b0;
      cfg.idx_load_n <= 1'b0;
      cfg.idx_sync   <= 1'b0;
      cfg.idx_pos    <= 1'b0;
      preset         <= '0;
    end else if (we) begin
      case (csel_e'(sel))
        SEL_MODE: begin
          cfg.dec   <= dec_e'(data[4:3]);
          cfg.cmode <= cmode_e'(data[2:1]);
          if (data[4:3] == DEC_SD_CODE) cfg.idx_sync <= 1'b0;
        end
        SEL_INPUT: begin
          cfg.ab_en      <= data[0];
          cfg.idx_load_n <= data[1];
        end
        SEL_INDEX: begin
          cfg.idx_sync <= data[0] && (cfg.dec != DEC_STEP_DIR);
          cfg.idx_pos  <= data[1];
        end
        default: preset <= data;
      endcase
    end
  end

endmodule

// File: rtl/qc_input_stage.sv
module qc_input_stage
  import qc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_a,
  input  logic in_b,
  input  logic in_idx,
  input  dec_e dec,
  input  logic ab_en,
  input  logic idx_load_n,
  input  logic idx_sync,
  input  logic idx_pos,
  output logic step_up,
  output logic step_dn,
  output logic idx_fire
);

  logic       a_q, b_q, a_p, b_p, i_q, i_p;
  logic [1:0] prv, cur;
  logic       q_fwd, q_rev, a_chg, raw_up, raw_dn;
  logic       act_now, act_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0; b_q <= 1'b0;
      a_p <= 1'b0; b_p <= 1'b0;
      i_q <= 1'b1; i_p <= 1'b1;
    end else begin
      a_q <= in_a; b_q <= in_b; i_q <= in_idx;
      a_p <= a_q;  b_p <= b_q;  i_p <= i_q;
    end
  end

  assign prv   = {a_p, b_p};
  assign cur   = {a_q, b_q};
  assign a_chg = a_q ^ a_p;

  // forward Gray order: 00 -> 10 -> 11 -> 01 -> 00
  always_comb begin
    q_fwd = 1'b0;
    q_rev = 1'b0;
    case (prv)
      2'b00: begin q_fwd = (cur == 2'b10); q_rev = (cur == 2'b01); end
      2'b10: begin q_fwd = (cur == 2'b11); q_rev = (cur == 2'b00); end
      2'b11: begin q_fwd = (cur == 2'b01); q_rev = (cur == 2'b10); end
      default: begin q_fwd = (cur == 2'b00); q_rev = (cur == 2'b11); end
    endcase
  end

  always_comb begin
    raw_up = 1'b0;
    raw_dn = 1'b0;
    case (dec)
      DEC_STEP_DIR: begin
        raw_up = a_q & ~a_p & b_q;
        raw_dn = a_q & ~a_p & ~b_q;
      end
      DEC_X1: begin
        raw_up = (prv == 2'b00) && (cur == 2'b10);
        raw_dn = (prv == 2'b10) && (cur == 2'b00);
      end
      DEC_X2: begin
        raw_up = q_fwd & a_chg;
        raw_dn = q_rev & a_chg;
      end
      default: begin
        raw_up = q_fwd;
        raw_dn = q_rev;
      end
    endcase
  end

  assign step_up = raw_up & ab_en;
  assign step_dn = raw_dn & ab_en;

  assign act_now  = idx_pos ? i_q : ~i_q;
  assign act_old  = idx_pos ? i_p : ~i_p;
  assign idx_fire = act_now & ~act_old & ~idx_load_n &
                    (~idx_sync | (~a_q & ~b_q));

endmodule

// File: rtl/qc_count_core.sv
module qc_count_core
  import qc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  cmode_e           cmode,
  input  logic [CNT_W-1:0] preset,
  input  logic             step_up,
  input  logic             step_dn,
  input  logic             load,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             carry,
  output logic             borrow,
  output logic             frozen
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] ceil_v, cnt_n;
  logic             dir_n, c_n, b_n, frz_n;

  assign ceil_v = (cmode == CM_RANGE || cmode == CM_MODULO) ? preset : MAXV;

  always_comb begin
    cnt_n = cnt;
    dir_n = dir_up;
    c_n   = 1'b0;
    b_n   = 1'b0;
    frz_n = frozen;
    if (load) begin
      cnt_n = preset;
      frz_n = 1'b0;
    end else if (step_up) begin
      dir_n = 1'b1;
      case (cmode)
        CM_NORMAL: begin
          if (cnt == MAXV) begin cnt_n = '0; c_n = 1'b1; end
          else cnt_n = cnt + ONE;
        end
        CM_RANGE: begin
          if (cnt >= ceil_v) c_n = 1'b1;
          else cnt_n = cnt + ONE;
        end
        CM_NOREC: begin
          if (!frozen) begin
            if (cnt == MAXV) begin cnt_n = '0; c_n = 1'b1; frz_n = 1'b1; end
            else cnt_n = cnt + ONE;
          end
        end
        default: begin
          if (cnt >= ceil_v) begin cnt_n = '0; c_n = 1'b1; end
          else cnt_n = cnt + ONE;
        end
      endcase
    end else if (step_dn) begin
      dir_n = 1'b0;
      case (cmode)
        CM_NORMAL: begin
          if (cnt == '0) begin cnt_n = MAXV; b_n = 1'b1; end
          else cnt_n = cnt - ONE;
        end
        CM_RANGE: begin
          if (cnt == '0) b_n = 1'b1;
          else cnt_n = cnt - ONE;
        end
        CM_NOREC: begin
          if (!frozen) begin
            if (cnt == '0) begin cnt_n = MAXV; b_n = 1'b1; frz_n = 1'b1; end
            else cnt_n = cnt - ONE;
          end
        end
        default: begin
          if (cnt == '0) begin cnt_n = ceil_v; b_n = 1'b1; end
          else cnt_n = cnt - ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      dir_up <= 1'b1;
      carry  <= 1'b0;
      borrow <= 1'b0;
      frozen <= 1'b0;
    end else begin
      cnt    <= cnt_n;
      dir_up <= dir_n;
      carry  <= c_n;
      borrow <= b_n;
      frozen <= frz_n;
    end
  end

endmodule

// File: rtl/quad_count_chan.sv
module quad_count_chan
  import qc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [CNT_W-1:0] cfg_data,
  input  logic             in_a,
  input  logic             in_b,
  input  logic             in_idx,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             carry_o,
  output logic             borrow_o,
  output logic             compare_o
);

  cfg_t             cfg_q;
  logic [CNT_W-1:0] preset_q;
  logic             step_up, step_dn, idx_fire, frozen_q;

  qc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we),
    .sel    (cfg_sel),
    .data   (cfg_data),
    .cfg    (cfg_q),
    .preset (preset_q)
  );

  qc_input_stage u_in (
    .clk        (clk),
    .rst        (rst),
    .in_a       (in_a),
    .in_b       (in_b),
    .in_idx     (in_idx),
    .dec        (cfg_q.dec),
    .ab_en      (cfg_q.ab_en),
    .idx_load_n (cfg_q.idx_load_n),
    .idx_sync   (cfg_q.idx_sync),
    .idx_pos    (cfg_q.idx_pos),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .idx_fire   (idx_fire)
  );

  qc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .cmode   (cfg_q.cmode),
    .preset  (preset_q),
    .step_up (step_up),
    .step_dn (step_dn),
    .load    (idx_fire),
    .cnt     (count_o),
    .dir_up  (dir_up_o),
    .carry   (carry_o),
    .borrow  (borrow_o),
    .frozen  (frozen_q)
  );

  assign compare_o = (count_o == preset_q);

endmodule

// File: rtl/qc_chan_chk.sv
module qc_chan_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic             carry,
  input logic             borrow,
  input logic [1:0]       cmode,
  input logic [1:0]       dec,
  input logic             ab_en,
  input logic             idx_sync,
  input logic             ld,
  input logic             frozen,
  input logic [CNT_W-1:0] preset
);

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_en && !ld) |=> $stable(cnt)); // R3

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(carry && borrow)); // R8

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (carry && ($past(cmode) == 2'd0 || $past(cmode) == 2'd3)) |-> (cnt == '0)); // R8

  AST_RANGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (carry && $past(cmode) == 2'd1) |-> (cnt == $past(cnt))); // R9

  AST_FROZEN_STILL: assert property (@(posedge clk) disable iff (rst)
    (frozen && cmode == 2'd2 && !ld) |=> $stable(cnt)); // R10

  AST_MOD_UNDER: assert property (@(posedge clk) disable iff (rst)
    (borrow && $past(cmode) == 2'd3) |-> (cnt == $past(preset))); // R11

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(preset))); // R12

  AST_SYNC_QUAD_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(idx_sync && dec == 2'd0)); // R13

endmodule

bind quad_count_chan qc_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cnt      (count_o),
  .carry    (carry_o),
  .borrow   (borrow_o),
  .cmode    (cfg_q.cmode),
  .dec      (cfg_q.dec),
  .ab_en    (cfg_q.ab_en),
  .idx_sync (cfg_q.idx_sync),
  .ld       (idx_fire),
  .frozen   (frozen_q),
  .preset   (preset_q)
);

// File: tb/quad_count_chan_tb.sv
`timescale 1ns/1ps
module quad_count_chan_tb;

  localparam int W = 24;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_sel = 2'd0;
  logic [W-1:0] cfg_data = '0;
  logic         in_a = 1'b0, in_b = 1'b0, in_idx = 1'b1;
  logic [W-1:0] count_o;
  logic         dir_up_o, carry_o, borrow_o, compare_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  quad_count_chan #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
    .count_o(count_o), .dir_up_o(dir_up_o), .carry_o(carry_o),
    .borrow_o(borrow_o), .compare_o(compare_o)
  );

  // {a, b, expected dir, expected count} for an x4 walk starting at 10, AB=00
  localparam logic [26:0] X4_VEC [0:7] = '{
    {1'b1, 1'b0, 1'b1, 24'd11},
    {1'b1, 1'b1, 1'b1, 24'd12},
    {1'b0, 1'b1, 1'b1, 24'd13},
    {1'b0, 1'b0, 1'b1, 24'd14},
    {1'b0, 1'b1, 1'b0, 24'd13},
    {1'b1, 1'b1, 1'b0, 24'd12},
    {1'b1, 1'b0, 1'b0, 24'd11},
    {1'b0, 1'b1, 1'b0, 24'd11}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ab(input logic a, input logic b);
    @(negedge clk);
    in_a = a; in_b = b;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idx(input logic v);
    @(negedge clk);
    in_idx = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", 32'(count_o), 0);
    chk("R1 dir", 32'(dir_up_o), 1);
    chk("R1 carry", 32'(carry_o), 0);
    chk("R1 borrow", 32'(borrow_o), 0);
    chk("R1 compare", 32'(compare_o), 1);

    // R3 gated off at reset
    ab(1'b1, 1'b1);
    chk("R3 gated count", 32'(count_o), 0);
    chk("R3 gated dir", 32'(dir_up_o), 1);
    ab(1'b0, 1'b0);

    // R2 enable A/B, index loading stays enabled
    wr(2'd1, 24'h1);
    // R4 step/direction
    ab(1'b0, 1'b1);
    chk("R4 B change", 32'(count_o), 0);
    ab(1'b1, 1'b1);
    chk("R4 rise up", 32'(count_o), 1);
    ab(1'b0, 1'b1);
    chk("R4 fall ignored", 32'(count_o), 1);
    ab(1'b0, 1'b0);
    ab(1'b1, 1'b0);
    chk("R4 rise down", 32'(count_o), 0);
    chk("R4 dir down", 32'(dir_up_o), 0);
    ab(1'b0, 1'b0);

    // R8 normal wrap both ways
    ab(1'b1, 1'b0);
    chk("R8 underflow count", 32'(count_o), 32'(MAXV));
    chk("R8 borrow pulse", 32'(borrow_o), 1);
    ab(1'b0, 1'b0);
    chk("R8 borrow drops", 32'(borrow_o), 0);
    ab(1'b0, 1'b1);
    ab(1'b1, 1'b1);
    chk("R8 overflow count", 32'(count_o), 0);
    chk("R8 carry pulse", 32'(carry_o), 1);
    ab(1'b0, 1'b0);
    chk("R8 carry drops", 32'(carry_o), 0);

    // R12 / R14 index load, active-low
    wr(2'd3, 24'd10);
    chk("R14 compare low", 32'(compare_o), 0);
    idx(1'b0);
    chk("R12 load", 32'(count_o), 10);
    chk("R14 compare high", 32'(compare_o), 1);
    idx(1'b1);

    // R7 x4 table
    wr(2'd0, 24'h18);
    for (int i = 0; i < 8; i++) begin
      ab(X4_VEC[i][26], X4_VEC[i][25]);
      chk("R7 x4 count", 32'(count_o), 32'(X4_VEC[i][23:0]));
      chk("R7 x4 dir", 32'(dir_up_o), 32'(X4_VEC[i][24]));
    end
    ab(1'b0, 1'b0);
    chk("R7 back to 00", 32'(count_o), 12);

    // R5 x1
    wr(2'd0, 24'h08);
    ab(1'b1, 1'b0);
    chk("R5 x1 first", 32'(count_o), 13);
    ab(1'b1, 1'b1); ab(1'b0, 1'b1); ab(1'b0, 1'b0);
    chk("R5 x1 fwd cycle", 32'(count_o), 13);
    ab(1'b0, 1'b1); ab(1'b1, 1'b1); ab(1'b1, 1'b0);
    chk("R5 x1 rev partial", 32'(count_o), 13);
    ab(1'b0, 1'b0);
    chk("R5 x1 rev cycle", 32'(count_o), 12);

    // R6 x2
    wr(2'd0, 24'h10);
    ab(1'b1, 1'b0); ab(1'b1, 1'b1); ab(1'b0, 1'b1); ab(1'b0, 1'b0);
    chk("R6 x2 fwd cycle", 32'(count_o), 14);

    // R9 range limit, ceiling 3
    wr(2'd3, 24'd3);
    idx(1'b0); idx(1'b1);
    wr(2'd0, 24'h1A);
    ab(1'b1, 1'b0);
    chk("R9 hold ceiling", 32'(count_o), 3);
    chk("R9 carry", 32'(carry_o), 1);
    ab(1'b0, 1'b0); ab(1'b0, 1'b1); ab(1'b1, 1'b1);
    chk("R9 reach zero", 32'(count_o), 0);
    ab(1'b1, 1'b0);
    chk("R9 hold zero", 32'(count_o), 0);
    chk("R9 borrow", 32'(borrow_o), 1);
    ab(1'b0, 1'b0);

    // R11 modulo-N, ceiling 4
    wr(2'd3, 24'd4);
    wr(2'd0, 24'h1E);
    ab(1'b0, 1'b1);
    chk("R11 under to ceil", 32'(count_o), 4);
    chk("R11 borrow", 32'(borrow_o), 1);
    ab(1'b0, 1'b0);
    chk("R11 over to zero", 32'(count_o), 0);
    chk("R11 carry", 32'(carry_o), 1);

    // R10 non-recycle
    wr(2'd3, MAXV);
    idx(1'b0); idx(1'b1);
    wr(2'd0, 24'h1C);
    ab(1'b1, 1'b0);
    chk("R10 wrap", 32'(count_o), 0);
    chk("R10 carry", 32'(carry_o), 1);
    ab(1'b1, 1'b1);
    chk("R10 frozen up", 32'(count_o), 0);
    ab(1'b1, 1'b0);
    chk("R10 frozen down", 32'(count_o), 0);
    idx(1'b0); idx(1'b1);
    ab(1'b0, 1'b0);
    chk("R10 runs after load", 32'(count_o), 32'(MAXV - 24'd1));

    // R12 load disabled
    wr(2'd1, 24'h3);
    wr(2'd3, 24'd100);
    idx(1'b0); idx(1'b1);
    chk("R12 load disabled", 32'(count_o), 32'(MAXV - 24'd1));
    wr(2'd1, 24'h1);

    // R12 active-high polarity
    wr(2'd2, 24'h2);
    idx(1'b0);
    chk("R12 inactive edge", 32'(count_o), 32'(MAXV - 24'd1));
    idx(1'b1);
    chk("R12 active-high load", 32'(count_o), 100);

    // R13 gated index in x4 normal
    wr(2'd0, 24'h18);
    wr(2'd2, 24'h3);
    wr(2'd3, 24'd50);
    ab(1'b1, 1'b0);
    chk("R13 pre count", 32'(count_o), 101);
    idx(1'b0); idx(1'b1);
    chk("R13 blocked by A", 32'(count_o), 101);
    ab(1'b0, 1'b0);
    idx(1'b0); idx(1'b1);
    chk("R13 gated load", 32'(count_o), 50);

    // R13 refused in step/direction
    wr(2'd0, 24'h00);
    wr(2'd2, 24'h3);
    wr(2'd3, 24'd7);
    ab(1'b0, 1'b1);
    idx(1'b0); idx(1'b1);
    chk("R13 refused, loads", 32'(count_o), 7);
    chk("R14 compare equal", 32'(compare_o), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule